// File: doc/BRIEF.md
# Parallel-Port Unlock Sequence Detector

This block sits on the device side of a host parallel port. It samples the eight data lines and the four control lines on the system clock. It waits for the host to present a fixed run of seven data values. The next data value after that run is taken as a command byte. The command is carried out only after the host pulses the control lines through a short strobe pattern. One command links the device to the host and another command unlinks it. While the run is in progress, the block places identification nibbles on the upper four status lines. This lets host software confirm that the device is present before it commits to a command.

A data value counts as a new byte only in the cycle it differs from the value seen in the previous cycle. A value held steady for many clocks is therefore counted once. The expected run is 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78, and the order is part of the behaviour. A byte that breaks the run sends the matcher back to its start. A breaking byte equal to 0xFE counts as the first byte of a fresh run. The link flag holds its value across any number of runs until a valid command changes it.

Top module: `pp_unlock_detect`

## Requirements
- R1: While `rst_n` is low, and after it rises, `id_nib` is 0x0, `linked` is 0 and `unlinked` is 0, and the matcher is at its first step.
- R2: A data value is consumed only in the clock where it differs from the previous clock's value. Holding one value for many cycles advances the matcher at most once.
- R3: A new byte that does not match the expected step returns the matcher to the start. If that byte is 0xFE, the matcher continues at step two. So after FE, AA, 13 the bytes 55, 00, FF do not give the ID nibble 0xB, while FE, AA, FE, AA, 55, 00, FF does.
- R4: `id_nib` reads 0xB from the clock after 0xFF is consumed as the fifth byte of the run. It reads 0x5 from the clock after 0x87 is consumed as the sixth byte. At every other step of the run it reads 0x0.
- R5: The first new byte after the complete seven-byte run is latched as the command. It is carried out only after `ctrl` has been sampled as 4, then 5, then 4. Other control values leave the strobe phase where it is. `id_nib` reads 0xF from the clock after the 5 is sampled until the final 4 is sampled.
- R6: Command 0x20 sets `linked` in the clock after the final strobe value 4 is sampled. `linked` then holds through any later data and control activity until an unlink command is carried out.
- R7: Command 0x30 clears `linked` in the clock after the final strobe value 4 is sampled. `unlinked` is high for exactly that one clock.
- R8: Command 0x00, or any value other than 0x20 or 0x30, leaves `linked` unchanged and does not pulse `unlinked`. The matcher returns to the start.
- R9: A new data byte that arrives while a command waits for its strobe abandons the command. That byte is treated as the first byte of a run, following R3. A later strobe then has no effect on `linked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is deasserted synchronously to `clk`. |
| pdata | input | 8 | Parallel data lines from the host |
| pctrl | input | 4 | Parallel control lines from the host |
| id_nib | output | 4 | Identification nibble for upper status lines |
| linked | output | 1 | Device is linked to the host |
| unlinked | output | 1 | One-clock pulse when an unlink command is carried out |

## Verification
The assertions assume that `pdata` and `pctrl` are already synchronous to `clk`. They also assume that each value is stable for at least one whole clock, so any change of `pdata` between two samples is a real new byte. The bench meets this by driving every input only on the falling clock edge and by holding each value for two clocks. The bench also assumes that the host never presents the same value twice in a row when it means two bytes. The stimulus therefore always moves the data lines to a different value, usually 0xFF, before it starts a fresh run.

// File: rtl/pp_unlock_pkg.sv
package pp_unlock_pkg;

  localparam int BYTE_W  = 8;
  localparam int CTRL_W  = 4;
  localparam int NIB_W   = 4;
  localparam int RUN_LEN = 7;
  localparam int IDX_W   = $clog2(RUN_LEN + 1);

  // Matcher steps: M0..M7 count bytes of the run already matched.
  // CA/CB/CC are the three phases of the command strobe.
  typedef enum logic [3:0] {
    ST_M0 = 4'd0, ST_M1 = 4'd1, ST_M2 = 4'd2, ST_M3 = 4'd3,
    ST_M4 = 4'd4, ST_M5 = 4'd5, ST_M6 = 4'd6, ST_M7 = 4'd7,
    ST_CA = 4'd8, ST_CB = 4'd9, ST_CC = 4'd10
  } step_t;

  localparam logic [BYTE_W-1:0] LEAD_BYTE  = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_LINK   = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_UNLINK = 8'h30;
  localparam logic [CTRL_W-1:0] CTRL_REST  = 4'h4;
  localparam logic [CTRL_W-1:0] CTRL_PULSE = 4'h5;

  localparam logic [NIB_W-1:0] NIB_NONE = 4'h0;
  localparam logic [NIB_W-1:0] NIB_HI   = 4'hB;
  localparam logic [NIB_W-1:0] NIB_MID  = 4'h5;
  localparam logic [NIB_W-1:0] NIB_LO   = 4'hF;

  // Expected byte for run position idx (0 = first byte)
  function automatic logic [BYTE_W-1:0] run_byte(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    run_byte = 8'hFE;
      3'd1:    run_byte = 8'hAA;
      3'd2:    run_byte = 8'h55;
      3'd3:    run_byte = 8'h00;
      3'd4:    run_byte = 8'hFF;
      3'd5:    run_byte = 8'h87;
      default: run_byte = 8'h78;
    endcase
  endfunction

endpackage

// File: rtl/pp_change_det.sv
module pp_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         new_byte
);

  logic [W-1:0] last_q;
  logic [W-1:0] last_d;
  logic         last_en;

  assign new_byte = (din != last_q);
  assign last_en  = new_byte;
  assign last_d   = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  AST_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    new_byte |=> (!new_byte || !$stable(din))); // R2

endmodule

// File: rtl/pp_seq_match.sv
module pp_seq_match
  import pp_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_byte,
  input  logic [BYTE_W-1:0] din,
  input  logic [CTRL_W-1:0] ctrl,
  output step_t             step,
  output logic              fire,
  output logic [BYTE_W-1:0] cmd
);

  step_t             step_q, step_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic              cmd_en;
  logic              in_run;
  step_t             restart;

  assign in_run  = (step_q < ST_M7);
  assign restart = (din == LEAD_BYTE) ? ST_M1 : ST_M0;

  always_comb begin
    step_d = step_q;
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    fire   = 1'b0;
    if (in_run) begin
      if (new_byte) begin
        if (din == run_byte(step_q[IDX_W-1:0])) step_d = step_t'(step_q + 4'd1);
        else                                     step_d = restart;
      end
    end else if (step_q == ST_M7) begin
      if (new_byte) begin
        cmd_d  = din;
        cmd_en = 1'b1;
        step_d = ST_CA;
      end
    end else if (new_byte) begin
      step_d = restart;
    end else begin
      case (step_q)
        ST_CA: if (ctrl == CTRL_REST)  step_d = ST_CB;
        ST_CB: if (ctrl == CTRL_PULSE) step_d = ST_CC;
        ST_CC: if (ctrl == CTRL_REST) begin
                 step_d = ST_M0;
                 fire   = 1'b1;
               end
        default: step_d = ST_M0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_M0;
      cmd_q  <= '0;
    end else begin
      step_q <= step_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign step = step_q;
  assign cmd  = cmd_q;

  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_M7 && new_byte) |=> (step_q == ST_CA && cmd_q == $past(din))); // R5

  AST_ABORT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= ST_CA && new_byte) |=> (step_q <= ST_M1)); // R9

  AST_HOLD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !new_byte) |=> $stable(step_q)); // R2

endmodule

// File: rtl/pp_link_reg.sv
module pp_link_reg
  import pp_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] cmd,
  output logic              linked,
  output logic              unlinked
);

  logic link_q, link_d, link_en;
  logic unl_q, unl_d;

  always_comb begin
    link_en = fire && (cmd == CMD_LINK || cmd == CMD_UNLINK);
    link_d  = (cmd == CMD_LINK);
    unl_d   = fire && (cmd == CMD_UNLINK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      unl_q  <= 1'b0;
    end else begin
      if (link_en) link_q <= link_d;
      unl_q <= unl_d;
    end
  end

  assign linked   = link_q;
  assign unlinked = unl_q;

  AST_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == CMD_LINK) |=> linked); // R6

  AST_UNLINK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    unlinked |-> !linked); // R7

  AST_UNLINK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unlinked |=> !unlinked); // R7

  AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || (cmd != CMD_LINK && cmd != CMD_UNLINK)) |=> ($stable(linked) && !unlinked)); // R8

endmodule

// File: rtl/pp_unlock_detect.sv
module pp_unlock_detect
  import pp_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pdata,
  input  logic [CTRL_W-1:0] pctrl,
  output logic [NIB_W-1:0]  id_nib,
  output logic              linked,
  output logic              unlinked
);

  logic              new_byte;
  step_t             step;
  logic              fire;
  logic [BYTE_W-1:0] cmd;

  pp_change_det #(.W(BYTE_W)) u_chg (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pdata),
    .new_byte (new_byte)
  );

  pp_seq_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_byte (new_byte),
    .din      (pdata),
    .ctrl     (pctrl),
    .step     (step),
    .fire     (fire),
    .cmd      (cmd)
  );

  pp_link_reg u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .cmd      (cmd),
    .linked   (linked),
    .unlinked (unlinked)
  );

  always_comb begin
    case (step)
      ST_M5:   id_nib = NIB_HI;
      ST_M6:   id_nib = NIB_MID;
      ST_CC:   id_nib = NIB_LO;
      default: id_nib = NIB_NONE;
    endcase
  end

  AST_NIB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (id_nib == NIB_NONE || id_nib == NIB_HI || id_nib == NIB_MID || id_nib == NIB_LO)); // R4

  AST_LO_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_nib == NIB_LO) |-> ($past(pctrl) == CTRL_PULSE)); // R5

  AST_HI_AFTER_FF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_nib == NIB_HI) |-> ($past(pdata) == 8'hFF)); // R4

endmodule

// File: tb/pp_unlock_detect_bench.sv
module pp_unlock_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic [3:0] pctrl = 4'h4;
  logic [3:0] id_nib;
  logic       linked, unlinked;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pp_unlock_detect u_pp_unlock_detect (
    .clk(clk), .rst_n(rst_n), .pdata(pdata), .pctrl(pctrl),
    .id_nib(id_nib), .linked(linked), .unlinked(unlinked)
  );

  // Behavioural reference model
  logic [7:0] run_q[$] = '{8'hFE, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h87, 8'h78};
  int         m_pos;    // 0..7 matched, 8..10 strobe phases
  int         m_last;
  int         m_cmd;
  bit         m_link, m_unl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_last = 0; m_cmd = 0; m_link = 0; m_unl = 0;
    end else begin
      bit ev;
      m_unl = 0;
      ev = (int'(pdata) != m_last);
      m_last = int'(pdata);
      if (m_pos < 7) begin
        if (ev) begin
          if (pdata == run_q[m_pos]) m_pos = m_pos + 1;
          else if (pdata == 8'hFE)   m_pos = 1;
          else                       m_pos = 0;
        end
      end else if (m_pos == 7) begin
        if (ev) begin m_cmd = int'(pdata); m_pos = 8; end
      end else if (ev) begin
        m_pos = (pdata == 8'hFE) ? 1 : 0;
      end else if (m_pos == 8 && pctrl == 4) m_pos = 9;
      else if (m_pos == 9 && pctrl == 5) m_pos = 10;
      else if (m_pos == 10 && pctrl == 4) begin
        if (m_cmd == 'h20) m_link = 1;
        if (m_cmd == 'h30) begin m_link = 0; m_unl = 1; end
        m_pos = 0;
      end
    end
  end

  function automatic logic [3:0] exp_nib();
    case (m_pos)
      5:  return 4'hB;
      6:  return 4'h5;
      10: return 4'hF;
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check({cur_req, " id_nib"},   {4'h0, id_nib},  {4'h0, exp_nib()});
    check({cur_req, " linked"},   {7'h0, linked},  {7'h0, m_link});
    check({cur_req, " unlinked"}, {7'h0, unlinked},{7'h0, m_unl});
  endtask

  task automatic put_byte(input logic [7:0] b);
    pdata = b; tick(); tick();
  endtask

  task automatic put_ctrl(input logic [3:0] c);
    pctrl = c; tick(); tick();
  endtask

  task automatic send_run();
    foreach (run_q[i]) put_byte(run_q[i]);
  endtask

  task automatic strobe();
    put_ctrl(4'h4); put_ctrl(4'h5); put_ctrl(4'h4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    check("R1 id_nib in reset", {4'h0, id_nib}, 8'h00);
    check("R1 linked in reset", {7'h0, linked}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    tick();
    check("R1 linked after reset", {7'h0, linked}, 8'h00);

    // R4 staged ID and R2 held bytes count once
    cur_req = "R4";
    pdata = 8'hFE; repeat (6) tick();
    put_byte(8'hAA); put_byte(8'h55); put_byte(8'h00);
    check("R2 no nibble before FF", {4'h0, id_nib}, 8'h00);
    pdata = 8'hFF; repeat (5) tick();
    check("R4 nibble B after FF", {4'h0, id_nib}, 8'h0B);
    put_byte(8'h87);
    check("R4 nibble 5 after 87", {4'h0, id_nib}, 8'h05);
    put_byte(8'h78);
    check("R4 nibble 0 after 78", {4'h0, id_nib}, 8'h00);

    // R5 / R6 command and strobe, link
    cur_req = "R6";
    put_byte(8'h20);
    put_ctrl(4'h4); put_ctrl(4'h5);
    check("R5 nibble F after pulse", {4'h0, id_nib}, 8'h0F);
    put_ctrl(4'h4);
    check("R6 linked after strobe", {7'h0, linked}, 8'h01);
    put_byte(8'hFF); put_ctrl(4'h5); put_ctrl(4'h4);
    check("R6 linked holds", {7'h0, linked}, 8'h01);

    // R3 break and restart on FE
    cur_req = "R3";
    put_byte(8'hFE); put_byte(8'hAA); put_byte(8'h13);
    put_byte(8'h55); put_byte(8'h00); put_byte(8'hFF);
    check("R3 broken run no B", {4'h0, id_nib}, 8'h00);
    put_byte(8'hFE); put_byte(8'hAA); put_byte(8'hFE); put_byte(8'hAA);
    put_byte(8'h55); put_byte(8'h00); put_byte(8'hFF);
    check("R3 FE restart gives B", {4'h0, id_nib}, 8'h0B);
    put_byte(8'h13);

    // R5 wrong control order, then R7 unlink
    cur_req = "R7";
    put_byte(8'hFF);
    send_run(); put_byte(8'h30);
    put_ctrl(4'h6); put_ctrl(4'h4); put_ctrl(4'h6); put_ctrl(4'h4);
    check("R5 no fire without pulse", {7'h0, linked}, 8'h01);
    put_ctrl(4'h5);
    pctrl = 4'h4; tick();
    check("R7 unlink pulse", {7'h0, unlinked}, 8'h01);
    check("R7 linked cleared", {7'h0, linked}, 8'h00);
    tick();
    check("R7 pulse one clock", {7'h0, unlinked}, 8'h00);

    // R9 abort by data change during strobe wait
    cur_req = "R9";
    put_byte(8'hFF);
    send_run(); put_byte(8'h20);
    put_byte(8'h11);
    strobe();
    check("R9 aborted command ignored", {7'h0, linked}, 8'h00);

    // R8 null and other commands
    cur_req = "R8";
    put_byte(8'hFF);
    send_run(); put_byte(8'h00); strobe();
    check("R8 null command no link", {7'h0, linked}, 8'h00);
    put_byte(8'hFF);
    send_run(); put_byte(8'h20); strobe();
    put_byte(8'hFF);
    send_run(); put_byte(8'h00); strobe();
    check("R8 null keeps link", {7'h0, linked}, 8'h01);
    put_byte(8'hFF);
    send_run(); put_byte(8'h44); strobe();
    check("R8 other keeps link", {7'h0, linked}, 8'h01);
    put_byte(8'hFF);
    send_run(); put_byte(8'h30); strobe();
    check("R7 final unlink", {7'h0, linked}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule